// File: doc/BRIEF.md
# Up/Down Timer Base Counter

This block is the counting core of a general-purpose timer. A counter of parameterised width (16 bits by default) runs against a programmable period in one of two ways. It can count in one direction, up or down. It can also count up and down in turn, the centre-aligned way. In that case the counter rises from zero to the period and then falls back to zero. Each time the counter wraps or turns in a direction that the selected mode names, an update event fires. The event sets a sticky flag. When period buffering is on, the event also moves a waiting period value into the active period.

Software configures the block through a small write port. A select code picks one of three targets: the control word, the period value, or the flag clear. The control word holds four fields: a sampling-clock divider, the period-buffer enable, the counting mode and the one-way direction. The block drives these outputs: the count, the present direction, the flag, the active period, a read-back copy of the control word, and a sampling enable that is high once every 1, 2 or 4 clocks. The counter steps only on cycles where `cnt_en` is high.

Top module: `updown_timebase`

## Requirements
- R1: A synchronous active-low reset clears the count, direction (0 = up), flag, active and waiting period and every control field. After reset the sampling enable is high every cycle.
- R2: Control read-back has clock division at bits 9:8, period-buffer enable at bit 7, mode at bits 6:5 and direction at bit 4 (1 = down). All other bits read 0. A divider code of 11 is stored and read back as 00.
- R3: The sampling enable is high on every cycle for divider code 00 (and 11), on every second cycle for code 01, and on every fourth cycle for code 10. It is driven from a free-running 2-bit cycle counter that resets to 0.
- R4: In mode 00 with direction 0, each enabled cycle adds one to the count. When the count is at or above the period, the next value is 0 and an update event fires.
- R5: In mode 00 with direction 1, each enabled cycle subtracts one from the count. When the count is 0, the next value is the period and an update event fires.
- R6: In modes 01, 10 and 11, the count rises to the period and then turns, giving period-1 with direction 1. It then falls to 0 and turns, giving 1 with direction 0. With a period of 0 the count stays at 0 and only the direction toggles.
- R7: Mode 01 fires an update event only at the bottom turn, mode 10 only at the top turn, and mode 11 at both turns.
- R8: A control write whose mode field is non-zero leaves the direction unchanged, whatever value bit 4 carries. A control write with mode 00 loads the direction from bit 4. This load takes priority over a turn in the same cycle.
- R9: With the period buffer off, a period write (select 01) becomes the active period on the next cycle.
- R10: With the period buffer on, a period write changes only the waiting value. The active period takes the waiting value on the cycle after an update event.
- R11: An update event sets the flag. The flag stays set until a status write (select 10) with bit 0 = 0 clears it. A status write with bit 0 = 1 has no effect. If an event and a clear fall in the same cycle, the event wins.
- R12: While `cnt_en` is low, the count and direction hold and no update event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 00 control, 01 period, 10 flag clear, 11 none |
| wr_data | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Present direction, 1 = down |
| upd_flag_o | output | 1 | Sticky update flag |
| samp_en_o | output | 1 | Divided sampling enable |
| period_o | output | CNT_W | Active period |
| ctrl_o | output | CNT_W | Control word read-back |

## Verification
The bench compares the full output state every cycle against its own model while a series of corner cases runs:
- **Turn values.** In the alternating modes, a design that turns one step late would report period+1 or wrap past zero.
- **Flag direction.** A design that swaps the direction tests of modes 01 and 10 raises the flag at the wrong end.
- **Buffered period.** A period write is placed in the middle of a count run, so a design that applies a buffered period at once shortens the current cycle.
- **Late period write.** A period is written below the running count with the buffer off, so a design that tests for equality instead of at-or-above runs on to the top of the counter range.
- **Field handling.** Writes of divider code 11 and of direction bits while an alternating mode is active expose designs that store reserved codes or let software flip the direction.
- **Flag clear.** A status write of 1 catches a flag that clears on any write.

// File: rtl/utb_pkg.sv
// Package: shared types and field positions for the up/down timer base.
// Assumes the data word is at least 10 bits wide so every control field fits.
package utb_pkg;

    // Counting modes: one-way, or alternating with the event at the bottom, top or both turns
    typedef enum logic [1:0] {
        MODE_ONEWAY   = 2'b00,
        MODE_ALT_DN   = 2'b01,
        MODE_ALT_UP   = 2'b10,
        MODE_ALT_BOTH = 2'b11
    } cnt_mode_e;

    // Sampling clock division codes
    typedef enum logic [1:0] {
        DIV_1   = 2'b00,
        DIV_2   = 2'b01,
        DIV_4   = 2'b10,
        DIV_RSV = 2'b11
    } div_e;

    // Write-port targets
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'b00,
        SEL_PERIOD = 2'b01,
        SEL_STATUS = 2'b10,
        SEL_NONE   = 2'b11
    } wsel_e;

    // Bit positions inside the control word
    localparam int DIV_LSB  = 8;
    localparam int PBUF_BIT = 7;
    localparam int MODE_LSB = 5;
    localparam int DIR_BIT  = 4;

    // Stored control fields (the direction lives in the counter)
    typedef struct packed {
        div_e      div;
        logic      pbuf;
        cnt_mode_e mode;
    } ctrl_t;

endpackage

// File: rtl/utb_clkdiv.sv
// Module: utb_clkdiv
// Makes the sampling enable from a free-running 2-bit cycle counter.
// Assumes the divider code has already been cleaned, so the reserved code
// never reaches it. The reserved code is still decoded as "no division" for safety.
module utb_clkdiv (
    input  logic          clk,
    input  logic          rst_n,
    input  utb_pkg::div_e div,
    output logic          samp_en
);
    import utb_pkg::*;

    localparam int CYC_W = 2;

    logic [CYC_W-1:0] cyc_q;

    // Free-running cycle counter, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + 1'b1;
    end

    // Decode the enable from the divider code and the cycle phase
    always_comb begin
        unique case (div)
            DIV_2:   samp_en = cyc_q[0];
            DIV_4:   samp_en = &cyc_q;
            default: samp_en = 1'b1;
        endcase
    end

    // R3: at divide-by-2 an enable pulse is never followed straight away by another
    assert_div2_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div == DIV_2 && samp_en) |=> (!samp_en || div != DIV_2));

    // R3: at divide-by-4 an enable pulse is followed by a quiet cycle
    assert_div4_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div == DIV_4 && samp_en) |=> (!samp_en || div != DIV_4));

endmodule

// File: rtl/utb_counter.sv
// Module: utb_counter
// Holds the count and the direction. It works out the next count for the
// one-way and alternating modes and flags the update event.
// Assumes the period and mode come from utb_regs. A direction load from a
// control write overrides any turn in the same cycle.
module utb_counter #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  utb_pkg::cnt_mode_e  mode,
    input  logic [CNT_W-1:0]    per,
    input  logic                dir_ld,
    input  logic                dir_ld_val,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                dir_q,
    output logic                upd_ev
);
    import utb_pkg::*;

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_nx;
    logic             dir_nx;
    logic             at_top;
    logic             at_bot;
    logic             ev_top;
    logic             ev_bot;

    // Limit detection and which turns of the alternating modes raise an event
    always_comb begin
        at_top = (cnt_q >= per);
        at_bot = (cnt_q == ZERO);
        ev_top = (mode == MODE_ALT_UP) || (mode == MODE_ALT_BOTH);
        ev_bot = (mode == MODE_ALT_DN) || (mode == MODE_ALT_BOTH);
    end

    // Next count, next direction and the update event
    always_comb begin
        cnt_nx = cnt_q;
        dir_nx = dir_q;
        upd_ev = 1'b0;
        if (cnt_en) begin
            if (mode == MODE_ONEWAY) begin
                if (!dir_q) begin
                    if (at_top) begin
                        cnt_nx = ZERO;
                        upd_ev = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end else begin
                    if (at_bot) begin
                        cnt_nx = per;
                        upd_ev = 1'b1;
                    end else begin
                        cnt_nx = cnt_q - ONE;
                    end
                end
            end else begin
                if (!dir_q) begin
                    if (at_top) begin
                        cnt_nx = at_bot ? ZERO : (cnt_q - ONE);
                        dir_nx = 1'b1;
                        upd_ev = ev_top;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end else begin
                    if (at_bot) begin
                        cnt_nx = (per == ZERO) ? ZERO : ONE;
                        dir_nx = 1'b0;
                        upd_ev = ev_bot;
                    end else begin
                        cnt_nx = cnt_q - ONE;
                    end
                end
            end
        end
        if (dir_ld) dir_nx = dir_ld_val;
    end

    // Count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            dir_q <= dir_nx;
        end
    end

    // R12: with counting disabled and no direction load, count and direction hold
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !dir_ld) |=> ($stable(cnt_q) && $stable(dir_q)));

    // R4: one-way up at or above the period wraps to zero
    assert_up_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode == MODE_ONEWAY && !dir_q && cnt_q >= per) |=> (cnt_q == ZERO));

    // R5: one-way down at zero reloads the period
    assert_dn_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode == MODE_ONEWAY && dir_q && cnt_q == ZERO) |=> (cnt_q == $past(per)));

    // R6: the alternating top turn steps to period-1 and counts down
    assert_top_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && mode != MODE_ONEWAY && !dir_q && cnt_q == per && per != ZERO && !dir_ld)
        |=> (dir_q && cnt_q == $past(per) - ONE));

    // R7: mode 01 raises events only while counting down, mode 10 only while counting up
    assert_ev_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ev && mode == MODE_ALT_DN) |-> dir_q);
    assert_ev_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ev && mode == MODE_ALT_UP) |-> !dir_q);

endmodule

// File: rtl/utb_regs.sv
// Module: utb_regs
// Decodes the write port into the control fields, the waiting and active
// period, and the sticky update flag. Also builds the control read-back.
// Assumes one write per cycle and an update event from utb_counter.
module utb_regs #(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                upd_ev,
    input  logic                dir_cur,
    output utb_pkg::ctrl_t      ctrl,
    output logic [CNT_W-1:0]    per_act,
    output logic                flag_q,
    output logic                dir_ld,
    output logic                dir_ld_val,
    output logic [CNT_W-1:0]    ctrl_rd
);
    import utb_pkg::*;

    logic             wr_ctrl;
    logic             wr_per;
    logic             wr_clr;
    logic [1:0]       div_raw;
    logic [1:0]       mode_raw;
    logic [CNT_W-1:0] per_pre;

    // Write decode and raw field extraction
    always_comb begin
        wr_ctrl    = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
        wr_per     = wr_en && (wsel_e'(wr_sel) == SEL_PERIOD);
        wr_clr     = wr_en && (wsel_e'(wr_sel) == SEL_STATUS) && !wr_data[0];
        div_raw    = wr_data[DIV_LSB+1:DIV_LSB];
        mode_raw   = wr_data[MODE_LSB+1:MODE_LSB];
        dir_ld     = wr_ctrl && (mode_raw == 2'b00);
        dir_ld_val = wr_data[DIR_BIT];
    end

    // Control fields, with the reserved divider code stored as no division
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '{div: DIV_1, pbuf: 1'b0, mode: MODE_ONEWAY};
        end else if (wr_ctrl) begin
            ctrl.div  <= (div_raw == 2'b11) ? DIV_1 : div_e'(div_raw);
            ctrl.pbuf <= wr_data[PBUF_BIT];
            ctrl.mode <= cnt_mode_e'(mode_raw);
        end
    end

    // Waiting period, written on every period write
    always_ff @(posedge clk) begin
        if (!rst_n)      per_pre <= '0;
        else if (wr_per) per_pre <= wr_data;
    end

    // Active period: written directly when unbuffered, loaded on an event when buffered
    always_ff @(posedge clk) begin
        if (!rst_n)                    per_act <= '0;
        else if (wr_per && !ctrl.pbuf) per_act <= wr_data;
        else if (ctrl.pbuf && upd_ev)  per_act <= per_pre;
    end

    // Sticky flag: an event sets it and wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (upd_ev) flag_q <= 1'b1;
        else if (wr_clr) flag_q <= 1'b0;
    end

    // Read-back word; unassigned bits stay zero
    always_comb begin
        ctrl_rd                        = '0;
        ctrl_rd[DIV_LSB+1:DIV_LSB]     = ctrl.div;
        ctrl_rd[PBUF_BIT]              = ctrl.pbuf;
        ctrl_rd[MODE_LSB+1:MODE_LSB]   = ctrl.mode;
        ctrl_rd[DIR_BIT]               = dir_cur;
    end

    // R2: the reserved divider code never reaches the stored field
    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.div != DIV_RSV);

    // R11: the flag holds unless a clear write arrives
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_clr) |=> flag_q);

    // R11: an update event always leaves the flag set
    assert_ev_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> flag_q);

    // R10: with buffering on and no event, the active period holds
    assert_buf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pbuf && !upd_ev) |=> $stable(per_act));

    // R9: an unbuffered period write lands in the active period next cycle
    assert_nobuf_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_per && !ctrl.pbuf) |=> (per_act == $past(wr_data)));

endmodule

// File: rtl/updown_timebase.sv
// Module: updown_timebase (top)
// Timer base counter with a programmable period, an optional period buffer,
// one-way or alternating counting and a divided sampling enable.
// Assumes a single clock and a synchronous active-low reset. CNT_W must be at
// least 10 so the control fields fit in the data word.
module updown_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_flag_o,
    output logic             samp_en_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] ctrl_o
);
    import utb_pkg::*;

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q;
    logic             upd_ev;
    logic             dir_ld;
    logic             dir_ld_val;

    utb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .upd_ev     (upd_ev),
        .dir_cur    (dir_q),
        .ctrl       (ctrl),
        .per_act    (per_act),
        .flag_q     (upd_flag_o),
        .dir_ld     (dir_ld),
        .dir_ld_val (dir_ld_val),
        .ctrl_rd    (ctrl_o)
    );

    utb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .mode       (ctrl.mode),
        .per        (per_act),
        .dir_ld     (dir_ld),
        .dir_ld_val (dir_ld_val),
        .cnt_q      (cnt_q),
        .dir_q      (dir_q),
        .upd_ev     (upd_ev)
    );

    utb_clkdiv u_clkdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (ctrl.div),
        .samp_en (samp_en_o)
    );

    // Drive the outputs from the sub-block state
    always_comb begin
        cnt_o    = cnt_q;
        dir_o    = dir_q;
        period_o = per_act;
    end

endmodule

// File: tb/updown_timebase_tb.sv
// Scoreboard bench. The driver task applies one cycle of stimulus, updates a
// model written from the requirements and queues the expected outputs. The
// monitor pops one item after each rising edge and compares it with the outputs.
module updown_timebase_tb;

    localparam int W = 16;
    localparam int PACK_W = 3*W + 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'b11;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] cnt_o, period_o, ctrl_o;
    logic         dir_o, upd_flag_o, samp_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [PACK_W-1:0] exp_q[$];
    string             tag_q[$];

    // model state
    logic [W-1:0] m_cnt = '0, m_per = '0, m_pre = '0;
    logic         m_dir = 1'b0, m_flag = 1'b0, m_pbuf = 1'b0;
    logic [1:0]   m_div = 2'b00, m_mode = 2'b00, m_cyc = 2'b00;

    always #2 clk = ~clk;

    updown_timebase #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cnt_o(cnt_o), .dir_o(dir_o),
        .upd_flag_o(upd_flag_o), .samp_en_o(samp_en_o), .period_o(period_o),
        .ctrl_o(ctrl_o)
    );

    function automatic logic [W-1:0] cw(input logic [1:0] dv, input logic pb,
                                        input logic [1:0] md, input logic dr);
        return {6'b0, dv, pb, md, dr, 4'b0};
    endfunction

    // Driver: one cycle of stimulus plus the expected result from the model
    task automatic step(input logic rn, input logic en, input logic we,
                        input logic [1:0] sel, input logic [W-1:0] d, input string tag);
        logic [W-1:0] ncnt;
        logic ndir, ev, samp;
        @(negedge clk);
        rst_n = rn; cnt_en = en; wr_en = we; wr_sel = sel; wr_data = d;
        if (!rn) begin
            m_cnt = '0; m_per = '0; m_pre = '0; m_dir = 0; m_flag = 0;
            m_pbuf = 0; m_div = 0; m_mode = 0; m_cyc = 0;
        end else begin
            ncnt = m_cnt; ndir = m_dir; ev = 0;
            if (en) begin
                if (m_mode == 2'b00) begin
                    if (!m_dir) begin
                        if (m_cnt >= m_per) begin ncnt = 0; ev = 1; end
                        else ncnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin ncnt = m_per; ev = 1; end
                        else ncnt = m_cnt - 1;
                    end
                end else if (!m_dir) begin
                    if (m_cnt >= m_per) begin
                        ncnt = (m_cnt == 0) ? 16'd0 : m_cnt - 1;
                        ndir = 1; ev = m_mode[1];
                    end else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        ncnt = (m_per == 0) ? 16'd0 : 16'd1;
                        ndir = 0; ev = m_mode[0];
                    end else ncnt = m_cnt - 1;
                end
            end
            if (we && sel == 2'b01) begin
                if (!m_pbuf) m_per = d;
                m_pre = d;
            end else if (m_pbuf && ev) m_per = m_pre;
            if (ev) m_flag = 1;
            else if (we && sel == 2'b10 && !d[0]) m_flag = 0;
            if (we && sel == 2'b00) begin
                m_div  = (d[9:8] == 2'b11) ? 2'b00 : d[9:8];
                m_pbuf = d[7];
                m_mode = d[6:5];
                if (d[6:5] == 2'b00) ndir = d[4];
            end
            m_cnt = ncnt; m_dir = ndir; m_cyc = m_cyc + 1;
        end
        samp = (m_div == 2'b01) ? m_cyc[0] : (m_div == 2'b10) ? (&m_cyc) : 1'b1;
        exp_q.push_back({m_cnt, m_dir, m_flag, samp, m_per, cw(m_div, m_pbuf, m_mode, m_dir)});
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 1, 0, 2'b11, '0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 2'b11, '0, tag);
    endtask

    // Monitor: compare the outputs one step after each rising edge
    always @(posedge clk) begin
        logic [PACK_W-1:0] e, a;
        string t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {cnt_o, dir_o, upd_flag_o, samp_en_o, period_o, ctrl_o};
            n_chk++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: cnt/dir/flag/samp/per/ctrl actual=%h/%b/%b/%b/%h/%h expected=%h/%b/%b/%b/%h/%h",
                         t, a[PACK_W-1 -: W], a[2*W+2], a[2*W+1], a[2*W], a[2*W-1 -: W], a[W-1:0],
                         e[PACK_W-1 -: W], e[2*W+2], e[2*W+1], e[2*W], e[2*W-1 -: W], e[W-1:0]);
            end
        end
    end

    initial begin
        // R1 reset state
        step(0, 0, 0, 2'b11, '0, "R1");
        step(0, 0, 0, 2'b11, '0, "R1");
        idle(3, "R1");
        // R3 sampling enable patterns, R2 reserved divider code
        step(1, 0, 1, 2'b00, cw(2'b01, 0, 2'b00, 0), "R3");
        idle(6, "R3");
        step(1, 0, 1, 2'b00, cw(2'b10, 0, 2'b00, 0), "R3");
        idle(8, "R3");
        step(1, 0, 1, 2'b00, cw(2'b11, 0, 2'b00, 0), "R2");
        idle(3, "R2");
        // R9 unbuffered period write, R4 one-way up
        step(1, 0, 1, 2'b01, 16'd5, "R9");
        step(1, 0, 1, 2'b00, cw(2'b00, 0, 2'b00, 0), "R4");
        run(15, "R4");
        // R11 status write of 1 ignored, then clear; R12 hold
        step(1, 0, 1, 2'b10, 16'd1, "R11");
        idle(2, "R12");
        step(1, 0, 1, 2'b10, 16'd0, "R11");
        // R5 one-way down
        step(1, 0, 1, 2'b00, cw(2'b00, 0, 2'b00, 1), "R5");
        run(15, "R5");
        // R8 mode 01 with direction bit 0 ignored, R6/R7 alternating
        step(1, 1, 1, 2'b00, cw(2'b00, 0, 2'b01, 0), "R8");
        run(24, "R6");
        step(1, 1, 1, 2'b10, 16'd0, "R11");
        run(12, "R7");
        idle(3, "R12");
        step(1, 1, 1, 2'b00, cw(2'b00, 0, 2'b10, 1), "R8");
        step(1, 1, 1, 2'b10, 16'd0, "R11");
        run(24, "R7");
        step(1, 1, 1, 2'b10, 16'd0, "R11");
        step(1, 1, 1, 2'b00, cw(2'b00, 0, 2'b11, 0), "R8");
        run(24, "R7");
        // R6 period zero in alternating mode
        step(1, 0, 1, 2'b01, 16'd0, "R6");
        run(6, "R6");
        step(1, 0, 1, 2'b01, 16'd5, "R6");
        // R10 buffered period
        step(1, 0, 1, 2'b00, cw(2'b00, 1, 2'b00, 0), "R10");
        run(2, "R10");
        step(1, 1, 1, 2'b01, 16'd3, "R10");
        run(20, "R10");
        step(1, 1, 1, 2'b01, 16'd9, "R10");
        run(25, "R10");
        // R9 unbuffered write below the running count
        step(1, 1, 1, 2'b00, cw(2'b00, 0, 2'b00, 0), "R9");
        run(6, "R9");
        step(1, 1, 1, 2'b01, 16'd2, "R9");
        run(6, "R9");
        // R2 all-ones control write
        step(1, 0, 1, 2'b00, 16'hFFFF, "R2");
        idle(2, "R2");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule